// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block forms the unsigned product of two N-bit numbers, one multiplier bit per add/shift pair of clock cycles. A single shared data bus feeds two operand registers. Each register has its own load strobe, and the strobes are driven by the surrounding logic. The multiplicand is held in register B. The multiplier goes into the low product register Q. A start pulse launches the run. The datapath holds an N-bit accumulator A with a carry flip-flop C, an N-bit ripple adder and a down counter P. A hard-wired one-hot controller sequences it. The 2N-bit result is read as A (upper half) joined to Q (lower half).

The controller has three states. ST_IDLE waits for `go`. Its transitions are IDLE→MUL0 when `go` is 1, which clears A and C and presets P to N-1, and IDLE→IDLE otherwise. ST_MUL0 adds B into C||A when the current multiplier bit Q[0] is 1, and leaves the registers alone when it is 0. It always takes MUL0→MUL1. ST_MUL1 shifts the chain C||A||Q right by one place with a zero entering C, and decrements P. It takes MUL1→MUL0 while P is not zero and MUL1→IDLE when P is zero, with P tested before the decrement. A run therefore occupies exactly 2N cycles. Register updates land on the clock edge that leaves a state.

Top module: `shiftadd_mult`

## Requirements
- R1: While `rst` is high, and after it is released until the first operation, `busy` and `done` are 0 and `product` is all zeros. A synchronous reset places the controller in ST_IDLE and clears A, C, P, B and Q.
- R2: In ST_IDLE, `ld_mcand` loads `din` into B and `ld_mplier` loads `din` into Q, at the next clock edge. Q is visible as `product[N-1:0]`, while `product[2N-1:N]` keeps its value. A load that coincides with `go` takes part in the run it starts.
- R3: `go` = 1 in ST_IDLE makes `busy` go high at the next edge. `busy` then stays high for exactly 2N cycles, alternating ST_MUL0 and ST_MUL1, and at the start of the run the upper product half reads zero.
- R4: When `busy` falls, `product` equals the full 2N-bit unsigned product of the B and Q values used for the run. This includes the cases where the adder carries out, such as all-ones times all-ones.
- R5: `done` is high for exactly one cycle, namely the first cycle after `busy` falls, and it is never high while `busy` is high.
- R6: While `busy` is high, `go`, `ld_mcand` and `ld_mplier` are ignored. The result of the run in progress and the register values after it are unchanged.
- R7: The controller state is always exactly one of three one-hot codes: ST_IDLE = 3'b001, ST_MUL0 = 3'b010, ST_MUL1 = 3'b100.
- R8: If `go` is still 1 in the cycle where `done` is high, a new run starts at once. It multiplies B by the lower product half left by the previous run, unless Q is reloaded in that cycle.
- R9: In ST_MUL0 with Q[0] = 0, A and C keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | N | Shared operand input bus |
| ld_mcand | input | 1 | Load strobe for the multiplicand register B (acts in ST_IDLE only) |
| ld_mplier | input | 1 | Load strobe for the multiplier register Q (acts in ST_IDLE only) |
| go | input | 1 | Start request, sampled in ST_IDLE |
| busy | output | 1 | High in ST_MUL0 and ST_MUL1 |
| done | output | 1 | One-cycle pulse after the last shift |
| product | output | 2N | A concatenated with Q |

## Verification
The bench goes after products whose upper half needs the adder carry, such as all-ones by all-ones and all-ones by one. A design that dropped C or failed to shift it back into A would lose the top bit there. Zero operands and a multiplier of one check that the counter gives exactly N iterations. An off-by-one in the zero test would shift the result by one place and stretch or shorten `busy`, which the cycle-by-cycle comparison of `busy` and `done` exposes. Loads and `go` arriving mid-run, a load coinciding with `go`, and `go` held high across `done` check that a controller accepting strobes outside ST_IDLE would corrupt the product, and that one not restarting from the done cycle would misalign the whole sequence.

// File: rtl/shm_pkg.sv
package shm_pkg;

    // One-hot controller state, one flip-flop per state
    typedef enum logic [2:0] {
        ST_IDLE = 3'b001,
        ST_MUL0 = 3'b010,
        ST_MUL1 = 3'b100
    } shm_state_e;

    // Control strobes from controller to datapath and counter
    typedef struct packed {
        logic init;   // clear A, preset P (IDLE and go)
        logic clr_c;  // clear carry flip-flop
        logic add;    // C||A <= A + B
        logic shift;  // shift C||A||Q right, decrement P
    } shm_ctrl_t;

endpackage

// File: rtl/shm_adder.sv
module shm_adder #(
    parameter int N = 8
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    output logic [N-1:0] sum,
    output logic         cout
);

    logic [N:0] cy;

    assign cy[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_fa
        assign sum[i]   = x[i] ^ y[i] ^ cy[i];
        assign cy[i+1]  = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
    end

    assign cout = cy[N];

endmodule

// File: rtl/shm_cnt.sv
module shm_cnt #(
    parameter int N = 8,
    localparam int W = (N > 2) ? $clog2(N) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic dec,
    output logic zero
);

    localparam logic [W-1:0] PRESET = W'(N - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= PRESET;
        end else if (dec) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !dec) |=> $stable(cnt));

    // R3
    cnt_preset_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (zero == (N == 1)));

endmodule

// File: rtl/shm_ctrl.sv
module shm_ctrl
    import shm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      go,
    input  logic      q_lsb,
    input  logic      cnt_zero,
    output shm_ctrl_t ctrl,
    output logic      idle,
    output logic      busy,
    output logic      done
);

    shm_state_e state, state_n;

    // Next-state selection
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: state_n = go ? ST_MUL0 : ST_IDLE;
            ST_MUL0: state_n = ST_MUL1;
            ST_MUL1: state_n = cnt_zero ? ST_IDLE : ST_MUL0;
            default: state_n = ST_IDLE;
        endcase
    end

    // State register and done flop
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= state_n;
            done  <= (state == ST_MUL1) && cnt_zero;
        end
    end

    // Output decode
    always_comb begin
        ctrl = '0;
        idle = 1'b0;
        busy = 1'b0;
        unique case (state)
            ST_IDLE: begin
                idle       = 1'b1;
                ctrl.init  = go;
                ctrl.clr_c = go;
            end
            ST_MUL0: begin
                busy     = 1'b1;
                ctrl.add = q_lsb;
            end
            ST_MUL1: begin
                busy       = 1'b1;
                ctrl.shift = 1'b1;
                ctrl.clr_c = 1'b1;
            end
            default: begin
                idle = 1'b0;
            end
        endcase
    end

    // R7
    onehot_state_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(state) == 1);

    // R3
    mul0_to_mul1_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MUL0) |=> (state == ST_MUL1));

    // R5
    finish_done_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MUL1 && cnt_zero) |=> (done && state == ST_IDLE));

    // R5
    done_in_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (state == ST_IDLE));

endmodule

// File: rtl/shm_dp.sv
module shm_dp
    import shm_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   din,
    input  logic           ld_b,
    input  logic           ld_q,
    input  logic           idle,
    input  shm_ctrl_t      ctrl,
    output logic           q_lsb,
    output logic [2*N-1:0] product
);

    logic [N-1:0] reg_b;
    logic [N-1:0] reg_q;
    logic [N-1:0] reg_a;
    logic         reg_c;
    logic [N-1:0] sum;
    logic         cout;

    shm_adder #(.N(N)) u_add (
        .x    (reg_a),
        .y    (reg_b),
        .sum  (sum),
        .cout (cout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_b <= '0;
            reg_q <= '0;
            reg_a <= '0;
            reg_c <= 1'b0;
        end else begin
            if (idle && ld_b) reg_b <= din;
            if (idle && ld_q) reg_q <= din;
            if (ctrl.shift) begin
                {reg_c, reg_a, reg_q} <= {1'b0, reg_c, reg_a, reg_q[N-1:1]};
            end else if (ctrl.add) begin
                {reg_c, reg_a} <= {cout, sum};
            end else if (ctrl.init) begin
                reg_a <= '0;
                if (ctrl.clr_c) reg_c <= 1'b0;
            end
        end
    end

    assign q_lsb   = reg_q[0];
    assign product = {reg_a, reg_q};

    // R6
    mcand_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !idle |=> $stable(reg_b));

    // R9
    no_add_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!idle && !ctrl.shift && !reg_q[0]) |=> ($stable(reg_a) && $stable(reg_c)));

    // R3
    carry_clear_after_shift_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.shift |=> !reg_c);

endmodule

// File: rtl/shiftadd_mult.sv
module shiftadd_mult
    import shm_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   din,
    input  logic           ld_mcand,
    input  logic           ld_mplier,
    input  logic           go,
    output logic           busy,
    output logic           done,
    output logic [2*N-1:0] product
);

    shm_ctrl_t ctrl;
    logic      idle;
    logic      q_lsb;
    logic      cnt_zero;

    shm_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .q_lsb    (q_lsb),
        .cnt_zero (cnt_zero),
        .ctrl     (ctrl),
        .idle     (idle),
        .busy     (busy),
        .done     (done)
    );

    shm_cnt #(.N(N)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .load (ctrl.init),
        .dec  (ctrl.shift),
        .zero (cnt_zero)
    );

    shm_dp #(.N(N)) u_dp (
        .clk     (clk),
        .rst     (rst),
        .din     (din),
        .ld_b    (ld_mcand),
        .ld_q    (ld_mplier),
        .idle    (idle),
        .ctrl    (ctrl),
        .q_lsb   (q_lsb),
        .product (product)
    );

    // R3
    start_clears_acc_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (product[2*N-1:N] == '0));

    // R5
    fall_gives_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R5
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

// File: tb/shiftadd_mult_tb.sv
`timescale 1ns/100ps
module shiftadd_mult_tb;

    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   din = '0;
    logic           ld_mcand = 1'b0;
    logic           ld_mplier = 1'b0;
    logic           go = 1'b0;
    logic           busy;
    logic           done;
    logic [2*N-1:0] product;

    int errors = 0;
    int checks = 0;
    bit comparing = 1'b0;

    always #2.5 clk = ~clk;

    shiftadd_mult #(.N(N)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .din       (din),
        .ld_mcand  (ld_mcand),
        .ld_mplier (ld_mplier),
        .go        (go),
        .busy      (busy),
        .done      (done),
        .product   (product)
    );

    // Behavioural reference model, updated on every rising edge
    logic [N-1:0]   m_b, m_q, m_a, nb, nq;
    logic [2*N-1:0] m_res;
    bit             m_busy, m_done;
    int             m_cnt;

    always @(posedge clk) begin
        if (rst) begin
            m_b = '0; m_q = '0; m_a = '0;
            m_busy = 0; m_done = 0; m_cnt = 0; m_res = '0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    m_busy = 0;
                    m_done = 1;
                    {m_a, m_q} = m_res;
                end
            end else begin
                nb = ld_mcand  ? din : m_b;
                nq = ld_mplier ? din : m_q;
                m_b = nb;
                m_q = nq;
                if (go) begin
                    m_res  = {{N{1'b0}}, nb} * {{N{1'b0}}, nq};
                    m_a    = '0;
                    m_busy = 1;
                    m_cnt  = 2 * N;
                end
            end
        end
    end

    task automatic check1(input string tag, input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (comparing && !rst) begin
            check1("R3 busy", {{(2*N-1){1'b0}}, busy}, {{(2*N-1){1'b0}}, m_busy});
            check1("R5 done", {{(2*N-1){1'b0}}, done}, {{(2*N-1){1'b0}}, m_done});
            if (!m_busy) check1("R4 R2 product", product, {m_a, m_q});
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic load_ops(input logic [N-1:0] x, input logic [N-1:0] y);
        din = x; ld_mcand = 1'b1; tick();
        ld_mcand = 1'b0; din = y; ld_mplier = 1'b1; tick();
        ld_mplier = 1'b0;
    endtask

    task automatic run_mul(input logic [N-1:0] x, input logic [N-1:0] y);
        load_ops(x, y);
        go = 1'b1; tick();
        go = 1'b0;
        repeat (2 * N) tick();
        // R4: explicit result check in the done cycle
        check1("R4 final", product, {{N{1'b0}}, x} * {{N{1'b0}}, y});
        check1("R5 pulse", {{(2*N-1){1'b0}}, done}, {{(2*N-1){1'b0}}, 1'b1});
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1: reset state while held in reset
        check1("R1 busy", {{(2*N-1){1'b0}}, busy}, '0);
        check1("R1 done", {{(2*N-1){1'b0}}, done}, '0);
        check1("R1 product", product, '0);
        rst = 1'b0;
        comparing = 1'b1;
        tick();
        check1("R1 after release", product, '0);

        // R2: load multiplier in idle, low half visible
        din = 8'hA5; ld_mplier = 1'b1; tick();
        ld_mplier = 1'b0; tick();
        check1("R2 load q", product, {8'h00, 8'hA5});

        // R4: corner operands
        run_mul(8'd0,   8'd0);
        run_mul(8'd0,   8'hFF);
        run_mul(8'hFF,  8'd0);
        run_mul(8'd1,   8'hFF);
        run_mul(8'hFF,  8'd1);
        run_mul(8'hFF,  8'hFF);
        run_mul(8'd5,   8'd3);
        run_mul(8'h80,  8'h80);
        run_mul(8'd1,   8'd1);

        for (int k = 0; k < 40; k++) begin
            run_mul(8'($urandom), 8'($urandom));
        end

        // R6: strobes during a run are ignored
        load_ops(8'd200, 8'd77);
        go = 1'b1; tick(); go = 1'b0;
        tick();
        din = 8'h3C; ld_mcand = 1'b1; ld_mplier = 1'b1; go = 1'b1; tick();
        ld_mcand = 1'b0; ld_mplier = 1'b0; tick();
        go = 1'b0;
        repeat (2 * N - 3) tick();
        check1("R6 result", product, 16'(200 * 77));
        tick();

        // R2: load coinciding with go takes part in the run
        din = 8'd9; ld_mcand = 1'b1; tick();
        din = 8'd13; ld_mcand = 1'b0; ld_mplier = 1'b1; go = 1'b1; tick();
        ld_mplier = 1'b0; go = 1'b0;
        repeat (2 * N) tick();
        check1("R2 same-edge", product, 16'(9 * 13));
        tick();

        // R8: go held high chains runs using previous low half
        load_ops(8'd3, 8'd5);
        go = 1'b1;
        repeat (3 * (2 * N + 1)) tick();
        go = 1'b0;
        repeat (2 * N + 2) tick();
        check1("R8 chain idle", {{(2*N-1){1'b0}}, busy}, '0);

        comparing = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule